// File: doc/BRIEF.md
# Row-Framed Serial Video Transmitter

This block takes rows of corrected RGB pixels from three row buffers and sends each row as a self-describing frame over three parallel source-synchronous serial groups. Group 0 carries row n of the picture, group 1 carries row n+GROUP_ROWS and group 2 carries row n+2*GROUP_ROWS. The three groups always run in lockstep and share one bit timing. Each group has four lanes: a shift clock plus one serial data lane each for red, green and blue.

Every frame opens with a header. The header holds a fixed pseudo-random 32-bit sync word, then the 8-bit local row index n, then an 8-bit routing ID that this transmitter always sends as zero. The pixel bits follow the header. The receiving controllers use the sync word to find the frame, use the row index to detect lost frames and to place the data, and use the ID to pick their share of the columns.

The picture height is not a multiple of the group height, so the last group holds fewer real rows (LAST_ROWS). For the remaining local rows that group sends zero pixels, and it neither waits for nor consumes its buffer. The bus scheduler that fills the buffers and the differential line drivers are outside this block.

Top module: `row_frame_tx`

## Requirements
- R1: While reset (rstN low) is applied and right after it, every serClk, serRed, serGreen, serBlue, pixPop and rowDone output is 0.
- R2: A frame begins only when a start request is pending and each group's row is available (rowAvail[g] high). A start pulse that arrives while rows are missing stays pending. The frame then begins on the first clock edge at which the missing rows are present.
- R3: Each frame begins with 48 header bits, sent MSB first: the 32-bit SYNC word, then the 8-bit local row index, then 8 zero ID bits. The same header bits appear on all three colour lanes of every group.
- R4: Each serial bit lasts two clock cycles. The shift clock is low in the first cycle and high in the second. The data lanes do not change between the two cycles. The shift clock and the data lanes are held low while no frame is in progress.
- R5: After the header, PIXELS pixels are sent. pixData[g][23:16] is red, [15:8] is green and [7:0] is blue. Each colour goes MSB first on its own lane.
- R6: Each non-padded group asserts pixPop[g] for exactly one cycle per pixel, PIXELS times per frame. The pop falls in the high half of the bit that comes before the pixel's first bit. The block takes pixData at the end of that cycle.
- R7: The row index starts at 0 after reset and rises by one per frame. After GROUP_ROWS-1 it wraps to 0.
- R8: For local rows >= LAST_ROWS, group 2 (the last group) sends its header normally but sends all-zero pixel bits. It never asserts pixPop[2], and rowAvail[2] is not needed to start the frame.
- R9: rowDone is high for exactly one cycle, in the cycle after the high half of the last pixel bit. In that cycle the shift clocks are already low.
- R10: All groups share one shift clock waveform, and their header bits are identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send the next row (one-cycle pulse) |
| rowAvail | input | NUM_GROUPS | Per group: its buffer holds a complete row |
| pixData | input | NUM_GROUPS x 3*COLOR_W | Per group: head-of-buffer pixel, red in the top byte |
| pixPop | output | NUM_GROUPS | Per group: advance the buffer by one pixel |
| serClk | output | NUM_GROUPS | Per group: source-synchronous shift clock |
| serRed | output | NUM_GROUPS | Per group: red serial lane |
| serGreen | output | NUM_GROUPS | Per group: green serial lane |
| serBlue | output | NUM_GROUPS | Per group: blue serial lane |
| rowDone | output | 1 | One-cycle pulse after a frame's final bit |

## Verification
Suppose a start request, with all rows present, is sampled at clock edge P0. Then bit k of the frame shows with a low clock in the cycle after edge P(2k) and with a high clock after P(2k+1). rowDone follows after P(2*(48+8*PIXELS)). The bench drives its inputs on falling edges and reads each bit at the falling edge inside each half. It therefore compares every lane at exactly those points against a header and pixel stream it builds itself. The pop for pixel j is due in the cycle after edge P(2*(48+8j)-1). The bench's buffer model moves to the next pixel only one cycle after it sees the pop, so a late or early capture changes the observed bits.

// File: rtl/rft_pkg.sv
package rft_pkg;

  localparam int SYNC_W = 32;
  localparam int ROW_W  = 8;
  localparam int ID_W   = 8;
  localparam int HDR_W  = SYNC_W + ROW_W + ID_W;
  localparam int LANES  = 3;

  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic             loadHdr;
    logic             loadPix;
    logic             shift;
    logic             inHdr;
    logic             inPix;
    logic             padLast;
    logic [ROW_W-1:0] rowNum;
  } rftStrobe_t;

endpackage

// File: rtl/rft_ctrl.sv
module rft_ctrl
  import rft_pkg::*;
#(
  parameter int NUM_GROUPS = 3,
  parameter int PIXELS     = 320,
  parameter int COLOR_W    = 8,
  parameter int GROUP_ROWS = 128,
  parameter int LAST_ROWS  = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [NUM_GROUPS-1:0] rowAvail,
  output rftStrobe_t            strb,
  output logic [NUM_GROUPS-1:0] pixPop,
  output logic                  serClkBase,
  output logic                  rowDone
);

  localparam int BIT_W  = $clog2(HDR_W);
  localparam int PIX_CW = $clog2(PIXELS + 1);
  localparam bit HAS_PAD = (LAST_ROWS < GROUP_ROWS);

  typedef enum logic [1:0] {PH_IDLE, PH_HDR, PH_PIX} phase_t;

  phase_t            phase;
  logic              half;
  logic [BIT_W-1:0]  bitCnt;
  logic [PIX_CW-1:0] pixCnt;
  logic [ROW_W-1:0]  rowNum;
  logic              armed;

  logic                  padRow;
  logic [NUM_GROUPS-1:0] need;
  logic                  go;
  logic                  inFrame;
  logic                  hdrEnd;
  logic                  pixBitEnd;
  logic                  lastPix;
  logic                  frameEnd;

  assign padRow    = HAS_PAD && (rowNum >= ROW_W'(LAST_ROWS));
  assign inFrame   = (phase != PH_IDLE);
  assign go        = (phase == PH_IDLE) && (armed || start) && (&need);
  assign hdrEnd    = (phase == PH_HDR) && half && (bitCnt == BIT_W'(HDR_W - 1));
  assign pixBitEnd = (phase == PH_PIX) && half && (bitCnt == BIT_W'(COLOR_W - 1));
  assign lastPix   = (pixCnt == PIX_CW'(PIXELS - 1));
  assign frameEnd  = pixBitEnd && lastPix;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    if (g == NUM_GROUPS - 1) begin : gLast
      assign need[g]   = rowAvail[g] | padRow;
      assign pixPop[g] = strb.loadPix & ~padRow;
    end else begin : gFull
      assign need[g]   = rowAvail[g];
      assign pixPop[g] = strb.loadPix;
    end
  end

  always_comb begin
    strb.loadHdr = go;
    strb.loadPix = hdrEnd || (pixBitEnd && !lastPix);
    strb.shift   = inFrame && half && !strb.loadPix && !frameEnd;
    strb.inHdr   = (phase == PH_HDR);
    strb.inPix   = (phase == PH_PIX);
    strb.padLast = padRow;
    strb.rowNum  = rowNum;
  end

  assign serClkBase = half;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      half    <= 1'b0;
      bitCnt  <= '0;
      pixCnt  <= '0;
      rowNum  <= '0;
      armed   <= 1'b0;
      rowDone <= 1'b0;
    end else begin
      rowDone <= 1'b0;
      if (go)         armed <= 1'b0;
      else if (start) armed <= 1'b1;

      case (phase)
        PH_IDLE: begin
          half <= 1'b0;
          if (go) begin
            phase  <= PH_HDR;
            bitCnt <= '0;
          end
        end
        default: begin
          half <= ~half;
          if (half) begin
            if (hdrEnd) begin
              phase  <= PH_PIX;
              bitCnt <= '0;
              pixCnt <= '0;
            end else if (pixBitEnd) begin
              bitCnt <= '0;
              if (lastPix) begin
                phase   <= PH_IDLE;
                rowDone <= 1'b1;
                rowNum  <= (rowNum == ROW_W'(GROUP_ROWS - 1)) ? '0 : rowNum + 1'b1;
              end else begin
                pixCnt <= pixCnt + 1'b1;
              end
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inFrame) |-> ($past(armed || start) && $past(&need))); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rowDone |=> !rowDone); // R9
  AST_DONE_CLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    rowDone |-> !serClkBase); // R9
  AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    rowNum < ROW_W'(GROUP_ROWS)); // R7
  AST_PAD_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    padRow |-> !pixPop[NUM_GROUPS-1]); // R8
  AST_POP_HIGH_HALF: assert property (@(posedge clk) disable iff (!rstN)
    (|pixPop) |-> serClkBase); // R6

endmodule

// File: rtl/rft_datapath.sv
module rft_datapath
  import rft_pkg::*;
#(
  parameter int                NUM_GROUPS = 3,
  parameter int                COLOR_W    = 8,
  parameter logic [SYNC_W-1:0] SYNC       = 32'hB3A5_1E27
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  rftStrobe_t                            strb,
  input  logic [NUM_GROUPS-1:0][LANES*COLOR_W-1:0] pixData,
  output logic [NUM_GROUPS-1:0][LANES-1:0]      laneOut
);

  localparam logic [ID_W-1:0] ID_SENT = '0;

  logic [HDR_W-1:0] hdrSr;
  logic [NUM_GROUPS-1:0][LANES-1:0][COLOR_W-1:0] pixSr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrSr <= '0;
      pixSr <= '0;
    end else begin
      if (strb.loadHdr)
        hdrSr <= {SYNC, strb.rowNum, ID_SENT};
      else if (strb.shift && strb.inHdr)
        hdrSr <= {hdrSr[HDR_W-2:0], 1'b0};

      for (int g = 0; g < NUM_GROUPS; g++) begin
        for (int c = 0; c < LANES; c++) begin
          if (strb.loadPix) begin
            if ((g == NUM_GROUPS - 1) && strb.padLast)
              pixSr[g][c] <= '0;
            else
              pixSr[g][c] <= pixData[g][(LANES-1-c)*COLOR_W +: COLOR_W];
          end else if (strb.shift && strb.inPix) begin
            pixSr[g][c] <= {pixSr[g][c][COLOR_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int c = 0; c < LANES; c++) begin
        if (strb.inHdr)      laneOut[g][c] = hdrSr[HDR_W-1];
        else if (strb.inPix) laneOut[g][c] = pixSr[g][c][COLOR_W-1];
        else                 laneOut[g][c] = 1'b0;
      end
    end
  end

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inPix && strb.padLast) |-> (laneOut[NUM_GROUPS-1] == '0)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.inHdr && !strb.inPix) |-> (laneOut == '0)); // R4

endmodule

// File: rtl/row_frame_tx.sv
module row_frame_tx
  import rft_pkg::*;
#(
  parameter int                NUM_GROUPS = 3,
  parameter int                PIXELS     = 320,
  parameter int                COLOR_W    = 8,
  parameter int                GROUP_ROWS = 128,
  parameter int                LAST_ROWS  = 64,
  parameter logic [SYNC_W-1:0] SYNC       = 32'hB3A5_1E27
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic                                     start,
  input  logic [NUM_GROUPS-1:0]                    rowAvail,
  input  logic [NUM_GROUPS-1:0][LANES*COLOR_W-1:0] pixData,
  output logic [NUM_GROUPS-1:0]                    pixPop,
  output logic [NUM_GROUPS-1:0]                    serClk,
  output logic [NUM_GROUPS-1:0]                    serRed,
  output logic [NUM_GROUPS-1:0]                    serGreen,
  output logic [NUM_GROUPS-1:0]                    serBlue,
  output logic                                     rowDone
);

  rftStrobe_t strb;
  logic       serClkBase;
  logic [NUM_GROUPS-1:0][LANES-1:0] laneOut;

  rft_ctrl #(
    .NUM_GROUPS(NUM_GROUPS), .PIXELS(PIXELS), .COLOR_W(COLOR_W),
    .GROUP_ROWS(GROUP_ROWS), .LAST_ROWS(LAST_ROWS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .rowAvail(rowAvail),
    .strb(strb), .pixPop(pixPop), .serClkBase(serClkBase), .rowDone(rowDone)
  );

  rft_datapath #(
    .NUM_GROUPS(NUM_GROUPS), .COLOR_W(COLOR_W), .SYNC(SYNC)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .pixData(pixData), .laneOut(laneOut)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gOut
    assign serClk[g]   = serClkBase;
    assign serRed[g]   = laneOut[g][0];
    assign serGreen[g] = laneOut[g][1];
    assign serBlue[g]  = laneOut[g][2];
  end

  AST_LANES_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    serClk[0] |-> $stable(laneOut)); // R4
  AST_HDR_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    strb.inHdr |-> (serRed == serGreen && serGreen == serBlue)); // R3

endmodule

// File: tb/sim_row_frame_tx.sv
`timescale 1ns/1ps
module sim_row_frame_tx;

  localparam int NG   = 3;
  localparam int PIX  = 3;
  localparam int GR   = 6;
  localparam int LR   = 4;
  localparam logic [31:0] SYNCW = 32'hB3A5_1E27;
  localparam int NBITS = 48 + 8 * PIX;

  // {row seed, rowAvail mask}; entries 3 and 4 land on padded rows 4 and 5
  localparam logic [26:0] VEC [0:7] = '{
    {24'hA51C30, 3'b111}, {24'h00FF00, 3'b111}, {24'h7E8101, 3'b111},
    {24'h13579B, 3'b011}, {24'hFFFFFF, 3'b011}, {24'hC3C3C3, 3'b111},
    {24'h2468AC, 3'b111}, {24'h800001, 3'b111}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NG-1:0] rowAvail = '0;
  logic [NG-1:0][23:0] pixData;
  logic [NG-1:0] pixPop, serClk, serRed, serGreen, serBlue;
  logic rowDone;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [23:0] curSeed = 24'h0;
  int idx [NG] = '{0, 0, 0};
  bit pend [NG] = '{0, 0, 0};
  int popCnt [NG] = '{0, 0, 0};
  int frameNo = 0;

  always #10 clk = ~clk;

  row_frame_tx #(.NUM_GROUPS(NG), .PIXELS(PIX), .COLOR_W(8), .GROUP_ROWS(GR),
                 .LAST_ROWS(LR), .SYNC(SYNCW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .rowAvail(rowAvail), .pixData(pixData),
    .pixPop(pixPop), .serClk(serClk), .serRed(serRed), .serGreen(serGreen),
    .serBlue(serBlue), .rowDone(rowDone)
  );

  function automatic logic [23:0] pat(input logic [23:0] s, input int g, input int j);
    return (s ^ 24'(g * 32'h3B5D17)) + 24'(j * 32'h10307);
  endfunction

  always_comb
    for (int g = 0; g < NG; g++) pixData[g] = pat(curSeed, g, idx[g]);

  // buffer model: advance one cycle after a pop is seen
  always @(negedge clk) begin
    for (int g = 0; g < NG; g++) begin
      if (rowDone) idx[g] <= 0;
      else if (pend[g]) idx[g] <= idx[g] + 1;
      pend[g] <= pixPop[g];
      if (pixPop[g]) popCnt[g] <= popCnt[g] + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic laneVal(input int g, input int c);
    return (c == 0) ? serRed[g] : (c == 1) ? serGreen[g] : serBlue[g];
  endfunction

  function automatic logic expBit(input int k, input int g, input int c,
                                  input logic [23:0] seed, input logic [7:0] row);
    logic [47:0] hdr;
    logic [23:0] px;
    int j, b;
    hdr = {SYNCW, row, 8'h00};
    if (k < 48) return hdr[47 - k];
    j = (k - 48) / 8;
    b = 7 - ((k - 48) % 8);
    if (g == NG - 1 && row >= 8'(LR)) return 1'b0;
    px = pat(seed, g, j);
    return px[(2 - c) * 8 + b];
  endfunction

  // Called at a falling edge. Starts a frame and checks every half-bit.
  task automatic sendFrame(input logic [23:0] seed, input logic [2:0] mask, input bit useStart);
    logic [7:0] row;
    bit pad;
    int base [NG];
    row = 8'(frameNo % GR);
    pad = (row >= 8'(LR));
    for (int g = 0; g < NG; g++) base[g] = popCnt[g];
    curSeed = seed;
    rowAvail = mask;
    if (useStart) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < NBITS; k++) begin
      for (int g = 0; g < NG; g++) begin
        check(serClk[g] == 1'b0, "R4 clk low half", int'(serClk[g]), 0);
        for (int c = 0; c < 3; c++)
          check(laneVal(g, c) == expBit(k, g, c, seed, row),
                (k < 48) ? "R3/R10 header bit" : (pad && g == NG-1) ? "R8 pad bit" : "R5 pixel bit",
                int'(laneVal(g, c)), int'(expBit(k, g, c, seed, row)));
      end
      check(rowDone == 1'b0, "R9 no early done", int'(rowDone), 0);
      @(negedge clk);
      for (int g = 0; g < NG; g++) begin
        check(serClk[g] == 1'b1, "R4 clk high half", int'(serClk[g]), 1);
        for (int c = 0; c < 3; c++)
          check(laneVal(g, c) == expBit(k, g, c, seed, row), "R4 lane stable in high half",
                int'(laneVal(g, c)), int'(expBit(k, g, c, seed, row)));
      end
      @(negedge clk);
    end
    check(rowDone == 1'b1, "R9 done pulse", int'(rowDone), 1);
    check(serClk == '0, "R9 clk low at done", int'(serClk), 0);
    for (int g = 0; g < NG; g++)
      check(popCnt[g] - base[g] == ((pad && g == NG-1) ? 0 : PIX),
            (g == NG-1) ? "R6/R8 pop count" : "R6 pop count",
            popCnt[g] - base[g], (pad && g == NG-1) ? 0 : PIX);
    frameNo++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(serClk == '0 && pixPop == '0 && rowDone == 1'b0, "R1 reset outputs",
          int'({serClk, pixPop, rowDone}), 0);
    check({serRed, serGreen, serBlue} == '0, "R1 reset lanes", int'({serRed, serGreen, serBlue}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(serClk == '0 && rowDone == 1'b0 && pixPop == '0, "R1 after reset",
          int'({serClk, pixPop, rowDone}), 0);

    // R2: start while group 2 has no row (row 0 is not padded) stays pending
    rowAvail = 3'b011;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 12; i++) begin
      check(serClk == '0 && pixPop == '0, "R2 held until rows ready", int'({serClk, pixPop}), 0);
      @(negedge clk);
    end
    sendFrame(24'h5AC3E1, 3'b111, 1'b0);  // R2 pending start fires, R7 row 0

    // table walk: rows 1..5, wrap to 0..2 (R7), padded rows 4 and 5 (R8)
    for (int v = 0; v < 8; v++)
      sendFrame(VEC[v][26:3], VEC[v][2:0], 1'b1);

    // R4: idle gap keeps clocks and lanes low
    for (int i = 0; i < 6; i++) begin
      check(serClk == '0 && {serRed, serGreen, serBlue} == '0, "R4 idle low",
            int'({serClk, serRed, serGreen, serBlue}), 0);
      @(negedge clk);
    end

    // R7: mid-run reset returns row index to 0
    rstN = 1'b0;
    @(negedge clk);
    check(serClk == '0 && rowDone == 1'b0, "R1 re-reset", int'({serClk, rowDone}), 0);
    rstN = 1'b1;
    frameNo = 0;
    sendFrame(24'h0F1E2D, 3'b111, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule